// File: doc/BRIEF.md
# I2C Downstream Channel Selector

This block is an I2C target that holds one control byte and turns it into a one-of-four channel enable for downstream bus segments. The block runs on a system clock that is much faster than the bus. It cleans up SCL and SDA with a synchronizer and a stability filter, and it recognises START and STOP conditions. It answers to a 7-bit address made of a fixed upper prefix and three strap pins.

A written selection is not applied at once. The block keeps it as pending and copies it into the live register only when the bus shows a STOP. Because of this, the downstream segments are switched only while the upstream bus is idle. A read returns the stored selection in the low bits. The upper nibble of the read byte shows the live state of four active-low interrupt inputs, one per channel. The control pins are plain level signals. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `i2c_chsel_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 1110 followed by strap_i[2:0] (strap_i[2] is the most significant of the three). The last bit of the address byte selects the direction: 1 means read and 0 means write.
- R2: After an address that does not match, the block drives nothing on SDA and ignores every following byte until the next START. This leaves the stored selection unchanged.
- R3: In a written byte, bit 2 is the enable and bits 1:0 are the channel number. When the enable is 1, ch_en_o has exactly bit [bits 1:0] set. When the enable is 0, ch_en_o is 0000. Bits 7:3 of a written byte are ignored.
- R4: A written byte changes neither ch_en_o nor the readback until a STOP appears on the bus.
- R5: Every data byte of a multi-byte write is acknowledged. Only the last byte received before the STOP takes effect.
- R6: A repeated START discards any written selection that no STOP has yet committed, and it starts address matching again.
- R7: A read byte is laid out as {interrupt active for channel 3..0, 0, stored bits 2:0}. A channel's interrupt bit is 1 when irq_n_i for that channel is low. The byte is sent MSB first.
- R8: When the master acknowledges a read byte, the block sends the byte again. When the master does not acknowledge, the block releases SDA and stays released until the next START.
- R9: After reset, ch_en_o is 0000, SDA is released, and a read returns 0 in bits 3:0.
- R10: A pulse on SCL or SDA that lasts FILT_CYC-1 system clocks or less has no effect on the protocol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line as sensed at the pin |
| sda_i | input | 1 | Bus data line as sensed at the pin |
| strap_i | input | 3 | Low three bits of the target address |
| irq_n_i | input | 4 | Active-low interrupt inputs, one per channel |
| ch_en_o | output | 4 | Registered one-hot downstream channel enable |
| sda_pull_o | output | 1 | When 1, the pad pulls SDA low |

## Verification
The bench tries every address low field against every strap setting. A decoder that ignored a strap bit would acknowledge addresses it should refuse. It writes all sixteen low-nibble values and checks the result against the arithmetic decode, which catches errors in the enable gating and in bit 3 masking. It watches ch_en_o between the data acknowledge and the STOP, and across a repeated START, to catch a design that applies a selection early or keeps a discarded one. It sweeps all sixteen interrupt patterns through reads, and it injects sub-threshold pulses on both lines in the middle of a byte. A filter that passed those pulses would see a false START/STOP pair or an extra bit, and the write would be lost.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int CH_N  = 4;
  localparam int SEL_W = $clog2(CH_N);
  localparam int ADR_W = 3;
  localparam logic [3:0] ADDR_PREFIX = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_IGN
  } st_t;
endpackage

// File: rtl/chsel_filt.sv
module chsel_filt #(
  parameter int FILT_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 != dout) begin
        if (cnt == CW'(FILT_CYC - 1)) begin
          dout <= s2;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  // R10: the filtered line only moves after the synchronized input has held the new level
  p_filt_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> ($past(s2, 1) == dout) && ($past(s2, 2) == dout));
endmodule

// File: rtl/chsel_fsm.sv
module chsel_fsm
  import chsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             scl,
  input  logic             sda,
  input  logic [ADR_W-1:0] strap,
  input  logic [7:0]       rd_byte,
  output logic             pull,
  output logic             wr_stb,
  output logic [SEL_W:0]   wr_dat,
  output logic             start_o,
  output logic             stop_o
);
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw, mnak, scl_q, sda_q;
  logic       scl_r, scl_f;

  assign scl_r   = scl & ~scl_q;
  assign scl_f   = ~scl & scl_q;
  assign start_o = scl & scl_q & sda_q & ~sda;
  assign stop_o  = scl & scl_q & ~sda_q & sda;
  assign wr_stb  = (st == ST_WDAT) && scl_f && (cnt == 4'd8);
  assign wr_dat  = sh[SEL_W:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0; mnak <= 1'b1;
      pull <= 1'b0; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (start_o) begin
        st <= ST_ADDR; cnt <= '0; pull <= 1'b0;
      end else if (stop_o) begin
        st <= ST_IDLE; pull <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_WDAT: begin
            if (scl_r) begin
              sh  <= {sh[6:0], sda};
              cnt <= cnt + 1'b1;
            end else if (scl_f && cnt == 4'd8) begin
              if (st == ST_WDAT) begin
                pull <= 1'b1; st <= ST_WACK;
              end else if (sh[7:1] == {ADDR_PREFIX, strap}) begin
                rw <= sh[0]; pull <= 1'b1; st <= ST_AACK;
              end else begin
                st <= ST_IGN;
              end
            end
          end
          ST_AACK, ST_WACK: begin
            if (scl_f) begin
              if (st == ST_AACK && rw) begin
                sh <= rd_byte; pull <= ~rd_byte[7]; cnt <= 4'd1; st <= ST_RDAT;
              end else begin
                pull <= 1'b0; cnt <= '0; st <= ST_WDAT;
              end
            end
          end
          ST_RDAT: begin
            if (scl_f) begin
              if (cnt == 4'd8) begin
                pull <= 1'b0; st <= ST_RACK;
              end else begin
                pull <= ~sh[6]; sh <= {sh[6:0], 1'b0}; cnt <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_r) mnak <= sda;
            else if (scl_f) begin
              if (!mnak) begin
                sh <= rd_byte; pull <= ~rd_byte[7]; cnt <= 4'd1; st <= ST_RDAT;
              end else begin
                st <= ST_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: the pull-down is only switched on while the filtered clock is low
  p_pull_low_scl_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(pull) |-> !scl);
  // R2: an ignored transaction never drives the line
  p_ign_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IGN) |-> !pull);
endmodule

// File: rtl/chsel_ctl.sv
module chsel_ctl
  import chsel_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_stb,
  input  logic [SEL_W:0] wr_dat,
  input  logic           start_i,
  input  logic           stop_i,
  output logic [SEL_W:0] sel,
  output logic [CH_N-1:0] ch_en
);
  logic [SEL_W:0] pend;
  logic           pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0; pend_v <= 1'b0; sel <= '0;
    end else if (start_i) begin
      pend_v <= 1'b0;
    end else if (stop_i) begin
      pend_v <= 1'b0;
      if (pend_v) sel <= pend;
    end else if (wr_stb) begin
      pend   <= wr_dat;
      pend_v <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < CH_N; i++) begin : g_en
      always_ff @(posedge clk) begin
        if (rst) ch_en[i] <= 1'b0;
        else     ch_en[i] <= sel[SEL_W] && (sel[SEL_W-1:0] == SEL_W'(i));
      end
    end
  endgenerate

  // R3: never more than one channel enabled
  p_onehot_r3: assert property (@(posedge clk) disable iff (rst) $onehot0(ch_en));
  // R4: the stored selection only changes right after a STOP
  p_sel_on_stop_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel) |-> $past(stop_i));
endmodule

// File: rtl/i2c_chsel_slave.sv
module i2c_chsel_slave
  import chsel_pkg::*;
#(
  parameter int FILT_CYC = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [2:0]  strap_i,
  input  logic [3:0]  irq_n_i,
  output logic [3:0]  ch_en_o,
  output logic        sda_pull_o
);
  logic [1:0]     raw, flt;
  logic           wr_stb, start_e, stop_e;
  logic [SEL_W:0] wr_dat, sel;
  logic [7:0]     rd_byte;

  assign raw     = {scl_i, sda_i};
  assign rd_byte = {~irq_n_i, 1'b0, sel};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_filt
      chsel_filt #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk(clk), .rst(rst), .din(raw[g]), .dout(flt[g]));
    end
  endgenerate

  chsel_fsm u_fsm (
    .clk(clk), .rst(rst), .scl(flt[1]), .sda(flt[0]), .strap(strap_i),
    .rd_byte(rd_byte), .pull(sda_pull_o), .wr_stb(wr_stb), .wr_dat(wr_dat),
    .start_o(start_e), .stop_o(stop_e));

  chsel_ctl u_ctl (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_dat(wr_dat),
    .start_i(start_e), .stop_i(stop_e), .sel(sel), .ch_en(ch_en_o));
endmodule

// File: tb/tb_i2c_chsel_slave.sv
module tb_i2c_chsel_slave;
  localparam int H  = 32;
  localparam int FC = 6;
  localparam int GL = FC - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'd5;
  logic [3:0] irq_n = 4'hF;
  logic [3:0] ch_en;
  logic sda_pull, sda_line;
  int checks = 0, errs = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  i2c_chsel_slave #(.FILT_CYC(FC)) dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .strap_i(strap),
    .irq_n_i(irq_n), .ch_en_o(ch_en), .sda_pull_o(sda_pull));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  function automatic logic [3:0] exp_en(input logic [7:0] v);
    return v[2] ? (4'b0001 << v[1:0]) : 4'b0000;
  endfunction

  task automatic i2c_start; m_sda = 1; w(H/2); m_scl = 1; w(H); m_sda = 0; w(H); m_scl = 0; w(H/2); endtask
  task automatic i2c_stop;  m_sda = 0; w(H/2); m_scl = 1; w(H); m_sda = 1; w(H); endtask

  // gsel: 1 = low pulse on SDA while SCL high, 2 = high pulse on SCL while low
  task automatic bit_io(input logic b, output logic r, input int gsel);
    m_sda = b;
    if (gsel == 2) begin w(4); m_scl = 1; w(GL); m_scl = 0; w(H/2 - 4 - GL); end
    else w(H/2);
    m_scl = 1;
    if (gsel == 1) begin w(4); m_sda = 0; w(GL); m_sda = b; w(H/2 - 4 - GL); end
    else w(H/2);
    r = sda_line; w(H/2); m_scl = 0; w(H/2);
  endtask

  task automatic send(input logic [7:0] d, output logic ack, input int gbit = -1, input int gsel = 0);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r, (i == gbit) ? gsel : 0);
    bit_io(1'b1, r, 0);
    ack = ~r;
  endtask

  task automatic recv(input logic nak, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r, 0); d[i] = r; end
    bit_io(nak, r, 0);
  endtask

  task automatic do_write(input logic [7:0] v, input string req);
    logic a;
    i2c_start; send({4'b1110, strap, 1'b0}, a); chk(req, a, 1);
    send(v, a); chk(req, a, 1); i2c_stop; w(20);
  endtask

  task automatic do_read(output logic [7:0] d, input string req);
    logic a;
    i2c_start; send({4'b1110, strap, 1'b1}, a); chk(req, a, 1);
    recv(1'b1, d); i2c_stop; w(20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d, d2;
    w(5); rst = 0; w(5);
    // R9 reset state
    chk("R9 ch_en", ch_en, 0); chk("R9 pull", sda_pull, 0);
    do_read(d, "R9"); chk("R9 readback", d[3:0], 0);

    // R1 exhaustive strap x address sweep
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int ad = 0; ad < 8; ad++) begin
        i2c_start; send({4'b1110, 3'(ad), 1'b0}, a); i2c_stop;
        chk("R1 addr match", a, ad == s);
      end
    end
    strap = 3'd5;
    i2c_start; send({4'b1100, strap, 1'b0}, a); i2c_stop; chk("R1 prefix", a, 0);

    // R3 exhaustive low nibble plus ignored high bits
    for (int v = 0; v < 16; v++) begin
      d2 = {4'(15 - v), 4'(v)};
      do_write(d2, "R3");
      chk("R3 ch_en", ch_en, exp_en(d2));
      do_read(d, "R3"); chk("R3 readback", d[3:0], {1'b0, d2[2:0]});
    end

    // R4 held until STOP
    do_write(8'h04, "R4");
    i2c_start; send({4'b1110, strap, 1'b0}, a); send(8'h06, a); chk("R4 ack", a, 1);
    w(40); chk("R4 before stop", ch_en, 4'b0001);
    i2c_stop; w(20); chk("R4 after stop", ch_en, 4'b0100);

    // R5 multi-byte, last wins
    i2c_start; send({4'b1110, strap, 1'b0}, a);
    send(8'h04, a); chk("R5 ack1", a, 1);
    send(8'h05, a); chk("R5 ack2", a, 1);
    send(8'h07, a); chk("R5 ack3", a, 1);
    i2c_stop; w(20); chk("R5 ch_en", ch_en, 4'b1000);

    // R6 repeated START discards pending
    i2c_start; send({4'b1110, strap, 1'b0}, a); send(8'h05, a);
    i2c_start; send({4'b1110, strap, 1'b1}, a); chk("R6 readdr", a, 1);
    recv(1'b1, d); i2c_stop; w(20);
    chk("R6 readback", d[2:0], 3'b111); chk("R6 ch_en", ch_en, 4'b1000);

    // R2 mismatched address ignores data
    i2c_start; send({4'b1110, 3'd2, 1'b0}, a); chk("R2 addr", a, 0);
    send(8'h04, a); chk("R2 data", a, 0); i2c_stop; w(20);
    chk("R2 ch_en", ch_en, 4'b1000);

    // R7 interrupt sweep
    for (int q = 0; q < 16; q++) begin
      irq_n = ~4'(q);
      do_read(d, "R7"); chk("R7 byte", d, {4'(q), 4'b0111});
    end
    irq_n = 4'hF;

    // R8 master ACK repeats, NACK releases
    i2c_start; send({4'b1110, strap, 1'b1}, a);
    recv(1'b0, d); recv(1'b1, d2);
    chk("R8 byte1", d, 8'h07); chk("R8 byte2", d2, 8'h07);
    bit_io(1'b1, a, 0); chk("R8 released", a, 1); chk("R8 pull", sda_pull, 0);
    i2c_stop; w(20);

    // R10 glitches below threshold
    i2c_start; send({4'b1110, strap, 1'b0}, a);
    send(8'h05, a, 0, 1); chk("R10 sda glitch ack", a, 1); i2c_stop; w(20);
    chk("R10 sda glitch", ch_en, 4'b0010);
    i2c_start; send({4'b1110, strap, 1'b0}, a);
    send(8'h06, a, 4, 2); chk("R10 scl glitch ack", a, 1); i2c_stop; w(20);
    chk("R10 scl glitch", ch_en, 4'b0100);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule